// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer for 9-bit words that carries data from a write clock domain into an unrelated read clock domain. A word is stored on a rising write-clock edge only when both write enables are high. A word is taken out on a rising read-clock edge only when both read enables are high. The storage depth is a power-of-two parameter, from 256 up to 8192 words.

Each side computes its own flags from its own pointer and a synchronized, Gray-coded copy of the other side's pointer. The write side drives `full` and an active-low near-full warning. The read side drives `empty` and an active-low near-empty warning. Both warning thresholds come from offset registers. Each offset register is loaded from a small parallel port in its own clock domain, and both return to 7 on reset. Because a pointer needs time to cross into the other domain, each flag sees the far side's activity a few cycles late. This lag only ever makes a flag more cautious.

Top module: `dcfifo_pflag`

## Requirements
- R1: Words leave `rdata` in the order they were accepted. `rdata` is registered and shows the word one read-clock edge after the edge that performs the read.
- R2: A write happens on a rising `wclk` edge only when `wen_a` and `wen_b` are both 1. With only one of them high, nothing is stored.
- R3: A read happens on a rising `rclk` edge only when `ren_a` and `ren_b` are both 1. With only one of them high, nothing is removed and `rdata` keeps its value.
- R4: While `full` is 1, a write attempt is ignored and stored data is not overwritten. Once the write side has seen DEPTH stored words, `full` is 1.
- R5: While `empty` is 1, a read attempt is ignored and `rdata` holds its value. Once the read side sees no stored words, `empty` is 1.
- R6: Let m be the near-full offset. After quiet settling, `afull_n` is 0 when the stored count is at least DEPTH-m, and 1 when the count is DEPTH-m-1 or less. It changes only on `wclk` edges.
- R7: Let n be the near-empty offset. After quiet settling, `aempty_n` is 0 when the stored count is n or less, and 1 when the count is n+1 or more. It changes only on `rclk` edges.
- R8: After reset both offsets are 7. A 1 on `af_ld` at a `wclk` edge loads `af_val` into m. A 1 on `ae_ld` at an `rclk` edge loads `ae_val` into n.
- R9: While `rst` is high, both pointers clear to zero. The outputs then read `empty`=1, `aempty_n`=0, `full`=0, `afull_n`=1 and `rdata`=0.
- R10: Each Gray-coded pointer changes by at most one bit per edge of its own clock. Under concurrent traffic, the lag across domains never leaves a warning flag or a hard flag inactive when the true count calls for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst | input | 1 | Active-high reset, sampled synchronously in each domain |
| wen_a | input | 1 | First write enable |
| wen_b | input | 1 | Second write enable |
| wdata | input | 9 | Word to store |
| af_ld | input | 1 | Load strobe for the near-full offset (wclk domain) |
| af_val | input | log2(DEPTH) | New near-full offset m |
| ren_a | input | 1 | First read enable |
| ren_b | input | 1 | Second read enable |
| ae_ld | input | 1 | Load strobe for the near-empty offset (rclk domain) |
| ae_val | input | log2(DEPTH) | New near-empty offset n |
| rdata | output | 9 | Registered output word |
| full | output | 1 | No room for another word (wclk domain) |
| empty | output | 1 | No word to read (rclk domain) |
| afull_n | output | 1 | Low when near full (wclk domain) |
| aempty_n | output | 1 | Low when near empty (rclk domain) |

## Verification
Two things can land in the same window: a write on one clock and a read on the other, while the stored count sits at a flag threshold. The bench provokes this with long random stretches of enables on both clocks. The clock periods never line up, and the rates are biased so that the count first climbs to full and then sinks toward empty. Every sample is judged against a queue model. A warning or hard flag must be active whenever the model's count demands it, and every word read must match the head of the queue. Exact flag values are checked only after both sides have been idle long enough for the pointers to settle.

// File: rtl/fifo_pf_pkg.sv
package fifo_pf_pkg;

    localparam int WORD_W  = 9;
    localparam int PTR_MAX = 14;

    typedef logic [WORD_W-1:0]  word_t;
    typedef logic [PTR_MAX-1:0] ptr_t;

    // hard: full or empty; soft_n: active-low near-threshold warning
    typedef struct packed {
        logic hard;
        logic soft_n;
    } flag_t;

    function automatic ptr_t bin_to_gray(input ptr_t b);
        return b ^ (b >> 1);
    endfunction

    function automatic ptr_t gray_to_bin(input ptr_t g);
        ptr_t b;
        b[PTR_MAX-1] = g[PTR_MAX-1];
        for (int i = PTR_MAX - 2; i >= 0; i--) begin
            b[i] = b[i+1] ^ g[i];
        end
        return b;
    endfunction

endpackage

// File: rtl/fifo_pf_sync.sv
module fifo_pf_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/fifo_pf_ofs.sv
module fifo_pf_ofs #(
    parameter int AW  = 8,
    parameter int DEF = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld,
    input  logic [AW-1:0] val,
    output logic [AW-1:0] off
);
    always_ff @(posedge clk) begin
        if (rst) begin
            off <= AW'(DEF);
        end else if (ld) begin
            off <= val;
        end
    end
endmodule

// File: rtl/fifo_pf_ptr.sv
module fifo_pf_ptr
    import fifo_pf_pkg::*;
#(
    parameter int AW    = 8,
    parameter bit IS_WR = 1'b1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [AW:0]   peer_gray,
    input  logic [AW-1:0] offset,
    output logic [AW:0]   gray,
    output logic [AW-1:0] addr,
    output logic          fire,
    output flag_t         flags
);
    localparam int          PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_C = PW'(1) << AW;
    localparam flag_t       RST_FLAGS = IS_WR ? flag_t'(2'b01) : flag_t'(2'b10);

    logic [PW-1:0] bin_q;
    logic [PW-1:0] bin_d;
    logic [PW-1:0] peer_bin;
    logic [PW-1:0] cnt_d;
    logic [PW:0]   limit;
    flag_t         flags_d;

    assign fire     = req & ~flags.hard;
    assign bin_d    = bin_q + PW'(fire);
    assign peer_bin = PW'(gray_to_bin(ptr_t'(peer_gray)));

    generate
        if (IS_WR) begin : g_wr
            assign cnt_d          = bin_d - peer_bin;
            assign limit          = {1'b0, DEPTH_C} - {2'b00, offset};
            assign flags_d.hard   = (cnt_d == DEPTH_C);
            assign flags_d.soft_n = ({1'b0, cnt_d} < limit);
        end else begin : g_rd
            assign cnt_d          = peer_bin - bin_d;
            assign limit          = {2'b00, offset};
            assign flags_d.hard   = (cnt_d == '0);
            assign flags_d.soft_n = ({1'b0, cnt_d} > limit);
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_q <= '0;
            flags <= RST_FLAGS;
        end else begin
            bin_q <= bin_d;
            flags <= flags_d;
        end
    end

    assign gray = PW'(bin_to_gray(ptr_t'(bin_q)));
    assign addr = bin_q[AW-1:0];
endmodule

// File: rtl/fifo_pf_ram.sv
module fifo_pf_ram
    import fifo_pf_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  word_t         wdata,
    input  logic          rclk,
    input  logic          rst,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    output word_t         rdata
);
    localparam int DEPTH = 1 << AW;

    word_t mem [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    always_ff @(posedge rclk) begin
        if (rst) begin
            rdata <= '0;
        end else if (re) begin
            rdata <= mem[raddr];
        end
    end
endmodule

// File: rtl/dcfifo_pflag.sv
module dcfifo_pflag
    import fifo_pf_pkg::*;
#(
    parameter int DEPTH = 256
) (
    input  logic                       wclk,
    input  logic                       rclk,
    input  logic                       rst,
    input  logic                       wen_a,
    input  logic                       wen_b,
    input  logic [WORD_W-1:0]          wdata,
    input  logic                       af_ld,
    input  logic [$clog2(DEPTH)-1:0]   af_val,
    input  logic                       ren_a,
    input  logic                       ren_b,
    input  logic                       ae_ld,
    input  logic [$clog2(DEPTH)-1:0]   ae_val,
    output logic [WORD_W-1:0]          rdata,
    output logic                       full,
    output logic                       empty,
    output logic                       afull_n,
    output logic                       aempty_n
);
    localparam int AW = $clog2(DEPTH);
    localparam int PW = AW + 1;

    logic [PW-1:0] wgray;
    logic [PW-1:0] rgray;
    logic [PW-1:0] wgray_in_r;
    logic [PW-1:0] rgray_in_w;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic [AW-1:0] af_off;
    logic [AW-1:0] ae_off;
    logic          wfire;
    logic          rfire;
    flag_t         wflags;
    flag_t         rflags;

    // write domain
    fifo_pf_ofs #(.AW(AW), .DEF(7)) u_af_ofs (
        .clk(wclk), .rst(rst), .ld(af_ld), .val(af_val), .off(af_off)
    );

    fifo_pf_sync #(.W(PW)) u_r2w (
        .clk(wclk), .rst(rst), .d(rgray), .q(rgray_in_w)
    );

    fifo_pf_ptr #(.AW(AW), .IS_WR(1'b1)) u_wptr (
        .clk(wclk), .rst(rst), .req(wen_a & wen_b),
        .peer_gray(rgray_in_w), .offset(af_off),
        .gray(wgray), .addr(waddr), .fire(wfire), .flags(wflags)
    );

    // read domain
    fifo_pf_ofs #(.AW(AW), .DEF(7)) u_ae_ofs (
        .clk(rclk), .rst(rst), .ld(ae_ld), .val(ae_val), .off(ae_off)
    );

    fifo_pf_sync #(.W(PW)) u_w2r (
        .clk(rclk), .rst(rst), .d(wgray), .q(wgray_in_r)
    );

    fifo_pf_ptr #(.AW(AW), .IS_WR(1'b0)) u_rptr (
        .clk(rclk), .rst(rst), .req(ren_a & ren_b),
        .peer_gray(wgray_in_r), .offset(ae_off),
        .gray(rgray), .addr(raddr), .fire(rfire), .flags(rflags)
    );

    fifo_pf_ram #(.AW(AW)) u_ram (
        .wclk(wclk), .we(wfire), .waddr(waddr), .wdata(wdata),
        .rclk(rclk), .rst(rst), .re(rfire), .raddr(raddr), .rdata(rdata)
    );

    assign full     = wflags.hard;
    assign afull_n  = wflags.soft_n;
    assign empty    = rflags.hard;
    assign aempty_n = rflags.soft_n;
endmodule

// File: rtl/pf_chk.sv
module pf_chk #(
    parameter int PW = 9
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst,
    input logic          wen_a,
    input logic          wen_b,
    input logic          ren_a,
    input logic          ren_b,
    input logic          full,
    input logic          empty,
    input logic          afull_n,
    input logic          aempty_n,
    input logic [8:0]    rdata,
    input logic [PW-1:0] wgray,
    input logic [PW-1:0] rgray
);
    // R4
    no_overflow_chk: assert property (@(posedge wclk) disable iff (rst)
        (full && wen_a && wen_b) |=> $stable(wgray));

    // R2
    wr_gate_chk: assert property (@(posedge wclk) disable iff (rst)
        !(wen_a && wen_b) |=> $stable(wgray));

    // R3
    rd_gate_chk: assert property (@(posedge rclk) disable iff (rst)
        !(ren_a && ren_b) |=> ($stable(rgray) && $stable(rdata)));

    // R5
    no_underflow_chk: assert property (@(posedge rclk) disable iff (rst)
        (empty && ren_a && ren_b) |=> ($stable(rgray) && $stable(rdata)));

    // R6
    full_warns_chk: assert property (@(posedge wclk) disable iff (rst)
        full |-> !afull_n);

    // R7
    empty_warns_chk: assert property (@(posedge rclk) disable iff (rst)
        empty |-> !aempty_n);

    // R10
    wgray_step_chk: assert property (@(posedge wclk) disable iff (rst)
        $onehot0(wgray ^ $past(wgray)));

    // R10
    rgray_step_chk: assert property (@(posedge rclk) disable iff (rst)
        $onehot0(rgray ^ $past(rgray)));
endmodule

bind dcfifo_pflag pf_chk #(.PW(PW)) u_chk (
    .wclk(wclk), .rclk(rclk), .rst(rst),
    .wen_a(wen_a), .wen_b(wen_b), .ren_a(ren_a), .ren_b(ren_b),
    .full(full), .empty(empty), .afull_n(afull_n), .aempty_n(aempty_n),
    .rdata(rdata), .wgray(wgray), .rgray(rgray)
);

// File: tb/tb_dcfifo_pflag.sv
`timescale 1ns/100ps
module tb_dcfifo_pflag;
    localparam int D  = 256;
    localparam int AW = 8;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst  = 1'b1;
    logic          wen_a = 1'b0, wen_b = 1'b0, ren_a = 1'b0, ren_b = 1'b0;
    logic [8:0]    wdata = '0;
    logic          af_ld = 1'b0, ae_ld = 1'b0;
    logic [AW-1:0] af_val = '0, ae_val = '0;
    logic [8:0]    rdata;
    logic          full, empty, afull_n, aempty_n;

    always #4.0 wclk = ~wclk;   // 125 MHz
    always #5.5 rclk = ~rclk;

    dcfifo_pflag #(.DEPTH(D)) dut (
        .wclk(wclk), .rclk(rclk), .rst(rst),
        .wen_a(wen_a), .wen_b(wen_b), .wdata(wdata),
        .af_ld(af_ld), .af_val(af_val),
        .ren_a(ren_a), .ren_b(ren_b),
        .ae_ld(ae_ld), .ae_val(ae_val),
        .rdata(rdata), .full(full), .empty(empty),
        .afull_n(afull_n), .aempty_n(aempty_n)
    );

    int         checks = 0;
    int         bad    = 0;
    logic [8:0] q[$];
    int         m_off  = 7;
    int         n_off  = 7;
    logic [8:0] nv     = 9'd1;
    logic [8:0] last_rd = '0;
    logic [8:0] rd_exp  = '0;
    bit         rd_pend = 1'b0;
    bit         done    = 1'b0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // write-side model, sampled 2 ns before each wclk edge
    always begin
        @(negedge wclk);
        #2.0;
        if (!rst) begin
            if (q.size() >= D - m_off) chk(!afull_n, "R10", "afull_n vs count", int'(afull_n), 0);
            if (q.size() == D)         chk(full, "R4", "full at depth", int'(full), 1);
            if (wen_a && wen_b && !full) q.push_back(wdata);
        end
    end

    // read-side model, sampled 3 ns before each rclk edge
    always begin
        @(negedge rclk);
        #2.5;
        if (rst) begin
            rd_pend = 1'b0;
            last_rd = '0;
        end else begin
            if (rd_pend) begin
                chk(rdata == rd_exp, "R1", "read word", int'(rdata), int'(rd_exp));
                last_rd = rd_exp;
                rd_pend = 1'b0;
            end else begin
                chk(rdata == last_rd, "R5", "rdata hold", int'(rdata), int'(last_rd));
            end
            if (q.size() <= n_off) chk(!aempty_n, "R10", "aempty_n vs count", int'(aempty_n), 0);
            if (q.size() == 0)     chk(empty, "R5", "empty at zero", int'(empty), 1);
            if (ren_a && ren_b && !empty) begin
                if (q.size() == 0) begin
                    chk(1'b0, "R5", "read while model empty", 1, 0);
                end else begin
                    rd_exp  = q.pop_front();
                    rd_pend = 1'b1;
                end
            end
        end
    end

    task automatic push(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge wclk);
            wdata = nv; nv = nv + 9'd1;
            wen_a = 1'b1; wen_b = 1'b1;
        end
        @(negedge wclk);
        wen_a = 1'b0; wen_b = 1'b0;
    endtask

    task automatic pop(input int cnt);
        for (int i = 0; i < cnt; i++) begin
            @(negedge rclk);
            ren_a = 1'b1; ren_b = 1'b1;
        end
        @(negedge rclk);
        ren_a = 1'b0; ren_b = 1'b0;
    endtask

    task automatic settle(input string req);
        int sz;
        repeat (8) @(negedge rclk);
        repeat (8) @(negedge wclk);
        sz = q.size();
        chk(full == (sz == D), req, "settled full", int'(full), int'(sz == D));
        chk(empty == (sz == 0), req, "settled empty", int'(empty), int'(sz == 0));
        chk(afull_n == !(sz >= D - m_off), req, "settled afull_n", int'(afull_n), int'(!(sz >= D - m_off)));
        chk(aempty_n == !(sz <= n_off), req, "settled aempty_n", int'(aempty_n), int'(!(sz <= n_off)));
    endtask

    task automatic traffic(input int wpct, input int rpct, input int n);
        fork
            begin
                for (int i = 0; i < n; i++) begin
                    @(negedge wclk);
                    wdata = nv; nv = nv + 9'd1;
                    wen_a = ($urandom % 100) < wpct;
                    wen_b = ($urandom % 100) < 95;
                end
                @(negedge wclk);
                wen_a = 1'b0; wen_b = 1'b0;
            end
            begin
                for (int i = 0; i < (n * 8) / 11; i++) begin
                    @(negedge rclk);
                    ren_a = ($urandom % 100) < rpct;
                    ren_b = ($urandom % 100) < 95;
                end
                @(negedge rclk);
                ren_a = 1'b0; ren_b = 1'b0;
            end
        join
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            chk(1'b0, "R9", "watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        repeat (6) @(negedge rclk);
        @(negedge wclk);
        rst = 1'b0;
        @(negedge wclk);
        // R9 reset state
        chk(empty == 1'b1, "R9", "empty after reset", int'(empty), 1);
        chk(full == 1'b0, "R9", "full after reset", int'(full), 0);
        chk(afull_n == 1'b1, "R9", "afull_n after reset", int'(afull_n), 1);
        chk(aempty_n == 1'b0, "R9", "aempty_n after reset", int'(aempty_n), 0);
        chk(rdata == 9'd0, "R9", "rdata after reset", int'(rdata), 0);

        // R2: one enable alone stores nothing
        @(negedge wclk); wdata = 9'h1AA; wen_a = 1'b1; wen_b = 1'b0;
        repeat (4) @(negedge wclk);
        wen_a = 1'b0; wen_b = 1'b1;
        repeat (4) @(negedge wclk);
        wen_b = 1'b0;
        settle("R2");

        // R8 default n=7 with R7 edges
        push(7);
        settle("R8");
        push(1);
        settle("R7");

        // R3: one read enable alone removes nothing
        @(negedge rclk); ren_a = 1'b1; ren_b = 1'b0;
        repeat (4) @(negedge rclk);
        ren_a = 1'b0; ren_b = 1'b1;
        repeat (4) @(negedge rclk);
        ren_b = 1'b0;
        settle("R3");

        // R1 ordered drain, then R5 reads on empty
        pop(8);
        settle("R1");
        pop(3);
        settle("R5");

        // R6 near-full edges with default m=7, then R4 overflow
        push(D - 8);
        settle("R6");
        push(1);
        settle("R6");
        push(7);
        settle("R4");
        push(3);
        settle("R4");
        pop(D);
        settle("R1");

        // R8 loaded offsets: m=20, n=3
        @(negedge wclk); af_val = AW'(20); af_ld = 1'b1;
        @(negedge wclk); af_ld = 1'b0; m_off = 20;
        @(negedge rclk); ae_val = AW'(3); ae_ld = 1'b1;
        @(negedge rclk); ae_ld = 1'b0; n_off = 3;
        push(3);
        settle("R8");
        push(1);
        settle("R8");
        push(D - 21 - 4);
        settle("R8");
        push(1);
        settle("R8");
        pop(D);
        settle("R7");

        // R10 concurrent traffic: climb, then sink
        traffic(90, 90, 1500);
        settle("R10");
        traffic(50, 95, 1500);
        settle("R10");
        pop(D + 4);
        settle("R10");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    end
endmodule